// File: doc/BRIEF.md
# MDIO Management Register Controller

This block runs one Clause 22 management transaction at a time to an external PHY over MDC and MDIO. Software sees two 32-bit registers. A data register holds the 16-bit value to be written. After a read transaction it also holds the value returned by the PHY. A command register holds the target PHY address, the PHY register number, the transfer direction, a preamble-skip option, the MDC divider code and a busy flag.

Software first loads the data register, if it is doing a write. It then writes the command word with the busy bit set. The controller shifts out the serial frame on MDIO, paced by MDC. For a read it releases the line, captures the 16 returned bits and stores them in the data register. It clears busy when the frame has finished.

MDC is generated only while a frame is in flight. It rests low at all other times.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset both registers read zero, MDC is low and the MDIO output enable is low.
- R2: The command word (bus_addr=1) carries the register number in bits [4:0], the PHY address in [12:8], the write flag in bit 16 (1 = write, 0 = read), busy in bit 17, preamble skip in bit 18 and the divider code in [23:20]. The stored fields read back in those positions and every other bit reads zero.
- R3: Writing the command word with bit 17 set while idle starts a transaction. Busy reads 1 until the frame ends and then reads 0. Writing the command word with bit 17 clear stores the fields and starts nothing.
- R4: A write frame drives MDIO for every bit, in this order: 32 ones, start 01, opcode 01, 5-bit PHY address MSB first, 5-bit register number MSB first, turnaround 10, then the data register's 16 bits MSB first.
- R5: A read frame sends opcode 10 and releases MDIO (output enable low) for the two turnaround bits and all 16 data bits. The data bits are sampled at MDC rising edges, and the 16-bit result sits in data register bits [15:0] once busy reads 0.
- R6: With bit 18 set, the frame omits the 32-bit preamble and begins directly with the start bits, for 32 MDC periods in total.
- R7: Each MDC half-period lasts the divider code times UNIT_CLKS system clocks, and a code of 0 acts as 1. MDC is low whenever busy is 0.
- R8: A command write while busy is 1 is ignored. The running frame, the stored fields and the busy state are unchanged, and no second frame follows.
- R9: The data register (bus_addr=0) stores write data bits [15:0] and reads them back with bits [31:16] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 data, 1 command |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the register selected by bus_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the controller |
| mdio_oe | output | 1 | MDIO output enable, high when the controller drives |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
The bench aims at the turnaround: a controller that keeps driving there, or that samples read data on the falling edge, shows up either as a driven bit in a released slot or as a read value shifted by one bit. Frames are run with the preamble skipped and with divider code 0 and with two other codes. A wrong frame length or a wrong half-period shows up as extra or missing MDC edges and as a measured half-width that differs from the code. A command write lands while a frame is running. A design that accepted that write would change the fields it reads back or would launch a second, unexpected frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int SHORT_BITS = 32;
    localparam int DATA_BITS  = 16;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int RELEASE_BITS = DATA_BITS + 2;

    // command word field positions
    localparam int CMD_REG_LSB = 0;
    localparam int CMD_PHY_LSB = 8;
    localparam int CMD_WR_BIT  = 16;
    localparam int CMD_BUSY_BIT = 17;
    localparam int CMD_SKIP_BIT = 18;
    localparam int CMD_DIV_LSB = 20;
    localparam int DIV_W       = 4;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             skip_pre;
        logic             wr;
        logic [4:0]       phy;
        logic [4:0]       regn;
    } mdio_cmd_t;

    function automatic mdio_cmd_t decode_cmd(input logic [31:0] w);
        mdio_cmd_t c;
        c.div      = w[CMD_DIV_LSB +: DIV_W];
        c.skip_pre = w[CMD_SKIP_BIT];
        c.wr       = w[CMD_WR_BIT];
        c.phy      = w[CMD_PHY_LSB +: 5];
        c.regn     = w[CMD_REG_LSB +: 5];
        return c;
    endfunction

    function automatic logic [31:0] encode_cmd(input mdio_cmd_t c, input logic busy);
        logic [31:0] w;
        w = '0;
        w[CMD_DIV_LSB +: DIV_W] = c.div;
        w[CMD_SKIP_BIT]         = c.skip_pre;
        w[CMD_BUSY_BIT]         = busy;
        w[CMD_WR_BIT]           = c.wr;
        w[CMD_PHY_LSB +: 5]     = c.phy;
        w[CMD_REG_LSB +: 5]     = c.regn;
        return w;
    endfunction

    // serial frame, index FRAME_BITS-1 goes out first
    function automatic logic [FRAME_BITS-1:0] frame_bits(input mdio_cmd_t c,
                                                         input logic [DATA_BITS-1:0] d);
        return {{SHORT_BITS{1'b1}}, 2'b01, (c.wr ? 2'b01 : 2'b10), c.phy, c.regn,
                (c.wr ? 2'b10 : 2'b11), (c.wr ? d : {DATA_BITS{1'b1}})};
    endfunction

    function automatic logic [FRAME_BITS-1:0] drive_mask(input mdio_cmd_t c);
        return c.wr ? {FRAME_BITS{1'b1}}
                    : {{(FRAME_BITS-RELEASE_BITS){1'b1}}, {RELEASE_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
#(
    parameter int UNIT_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_p,
    output logic             fall_p
);
    localparam int CW = DIV_W + $clog2(UNIT_CLKS + 1) + 1;

    logic [CW-1:0] half;
    logic [CW-1:0] cnt_q;

    always_comb begin
        half = CW'((div == '0) ? 1 : div) * CW'(UNIT_CLKS);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q  <= '0;
            mdc    <= 1'b0;
            rise_p <= 1'b0;
            fall_p <= 1'b0;
        end else begin
            rise_p <= 1'b0;
            fall_p <= 1'b0;
            if (cnt_q == half - 1'b1) begin
                cnt_q  <= '0;
                mdc    <= ~mdc;
                rise_p <= ~mdc;
                fall_p <= mdc;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R7
    half_cnt_chk: assert property (@(posedge clk) disable iff (rst) cnt_q < half);

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  mdio_cmd_t            cmd,
    input  logic [DATA_BITS-1:0] wdata,
    input  logic                 rise_p,
    input  logic                 fall_p,
    input  logic                 mdio_i,
    output logic                 active,
    output logic                 done,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic [DATA_BITS-1:0] rdata
);
    logic [FRAME_BITS-1:0] frame_q;
    logic [FRAME_BITS-1:0] mask_q;
    logic [IDX_W-1:0]      idx_q;
    logic                  is_rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            idx_q   <= '0;
            frame_q <= '0;
            mask_q  <= '0;
            is_rd_q <= 1'b0;
            rdata   <= '0;
        end else if (start) begin
            active  <= 1'b1;
            idx_q   <= cmd.skip_pre ? IDX_W'(SHORT_BITS - 1) : IDX_W'(FRAME_BITS - 1);
            frame_q <= frame_bits(cmd, wdata);
            mask_q  <= drive_mask(cmd);
            is_rd_q <= ~cmd.wr;
            rdata   <= '0;
        end else if (active) begin
            if (rise_p && is_rd_q && (idx_q < IDX_W'(DATA_BITS)))
                rdata <= {rdata[DATA_BITS-2:0], mdio_i};
            if (fall_p) begin
                if (idx_q == '0)
                    active <= 1'b0;
                else
                    idx_q <= idx_q - 1'b1;
            end
        end
    end

    always_comb begin
        done    = active & fall_p & (idx_q == '0);
        mdio_o  = active & frame_q[idx_q];
        mdio_oe = active & mask_q[idx_q];
    end

    // R5
    rd_release_chk: assert property (@(posedge clk) disable iff (rst)
        (active && is_rd_q && idx_q < IDX_W'(RELEASE_BITS)) |-> !mdio_oe);

    // R4
    wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !is_rd_q) |-> mdio_oe);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int UNIT_CLKS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic        bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_cmd_t            cmd_q;
    logic                 busy_q;
    logic [DATA_BITS-1:0] data_q;
    mdio_cmd_t            new_cmd;
    logic                 cmd_wr;
    logic                 start;
    logic                 active;
    logic                 done;
    logic                 rise_p;
    logic                 fall_p;
    logic [DATA_BITS-1:0] rdata;

    always_comb begin
        new_cmd = decode_cmd(bus_wdata);
        cmd_wr  = bus_we & bus_addr & ~busy_q;
        start   = cmd_wr & bus_wdata[CMD_BUSY_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            busy_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (bus_we && !bus_addr)
                data_q <= bus_wdata[DATA_BITS-1:0];
            if (cmd_wr) begin
                cmd_q  <= new_cmd;
                busy_q <= bus_wdata[CMD_BUSY_BIT];
            end
            if (done) begin
                busy_q <= 1'b0;
                if (!cmd_q.wr)
                    data_q <= rdata;
            end
        end
    end

    always_comb begin
        bus_rdata = bus_addr ? encode_cmd(cmd_q, busy_q) : {{(32-DATA_BITS){1'b0}}, data_q};
    end

    mdio_clkgen #(.UNIT_CLKS(UNIT_CLKS)) i_clkgen (
        .clk    (clk),
        .rst    (rst),
        .en     (active),
        .div    (cmd_q.div),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    mdio_frame i_frame (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cmd     (new_cmd),
        .wdata   (data_q),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .mdio_i  (mdio_i),
        .active  (active),
        .done    (done),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rdata   (rdata)
    );

    // R7
    mdc_idle_chk: assert property (@(posedge clk) disable iff (rst) !busy_q |-> !mdc);

    // R8
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && bus_we && bus_addr) |=> ($stable(cmd_q) && busy_q));

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && bus_we && bus_addr && bus_wdata[CMD_BUSY_BIT]) |=> (busy_q && active));

endmodule

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
    localparam int UNIT = 2;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [2:0] exp_q[$];   // {oe, value, compare value}
    int   fall_cnt = 0;
    int   fall_base = 0;
    int   cur_n = 64;
    logic [15:0] cur_resp = '0;
    longint rise_t = 0;
    longint meas_half = 0;

    always #(CLK_NS/2) clk = ~clk;

    mdio_mgmt_ctrl #(.UNIT_CLKS(UNIT)) i_mdio_mgmt_ctrl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY side: second turnaround bit low, then the response MSB first
    function automatic logic phy_bit(input int k, input int n, input logic [15:0] r);
        if (k == n - 17) return 1'b0;
        if (k >= n - 16 && k < n) return r[n - 1 - k];
        return 1'b1;
    endfunction
    assign mdio_i = phy_bit(fall_cnt - fall_base, cur_n, cur_resp);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compare each MDC rising edge against the scoreboard
    always @(posedge mdc) begin
        logic [2:0] e;
        rise_t = $time;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected MDC edge", 1, 0);
        end else begin
            e = exp_q.pop_front();
            chk(mdio_oe == e[2], "R4/R5 output enable", mdio_oe, e[2]);
            if (e[0]) chk(mdio_o == e[1], "R4/R6 frame bit", mdio_o, e[1]);
        end
    end

    always @(negedge mdc) begin
        fall_cnt++;
        meas_half = ($time - rise_t) / CLK_NS;
    end

    task automatic bus_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] cmd_word(input bit wr, input bit skip, input int dv,
                                             input logic [4:0] phy, input logic [4:0] rg,
                                             input bit busy);
        return (32'(dv) << 20) | (32'(skip) << 18) | (32'(busy) << 17) |
               (32'(wr) << 16) | (32'(phy) << 8) | 32'(rg);
    endfunction

    // driver: push expected bits, load data, start the frame
    task automatic issue(input bit wr, input bit skip, input int dv, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] wd, input logic [15:0] resp);
        logic [63:0] f;
        logic [63:0] m;
        logic [31:0] r;
        int top;
        f = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, (wr ? wd : 16'h0)};
        m = wr ? {64{1'b1}} : {{46{1'b1}}, 18'h0};
        top = skip ? 31 : 63;
        for (int i = top; i >= 0; i--) exp_q.push_back({m[i], f[i], m[i]});
        cur_n = top + 1;
        cur_resp = resp;
        fall_base = fall_cnt;
        if (wr) bus_write(1'b0, {16'h0, wd});
        bus_write(1'b1, cmd_word(wr, skip, dv, phy, rg, 1'b1));
        bus_read(1'b1, r);
        chk(r[17] == 1'b1, "R3 busy after start", r[17], 1);
    endtask

    task automatic finish_tx(input int dv);
        logic [31:0] r;
        int eff;
        r = 32'h0002_0000;
        for (int k = 0; k < 20000 && r[17]; k++) bus_read(1'b1, r);
        chk(r[17] == 1'b0, "R3 busy cleared", r[17], 0);
        chk(exp_q.size() == 0, "R4/R6 frame length", exp_q.size(), 0);
        eff = (dv == 0) ? 1 : dv;
        chk(meas_half == longint'(eff * UNIT), "R7 MDC half period", meas_half, eff * UNIT);
        chk(mdc == 1'b0, "R7 MDC idle low", mdc, 0);
    endtask

    initial begin
        #(200000 * CLK_NS);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(1'b0, r); chk(r == 0, "R1 data reg reset", r, 0);
        bus_read(1'b1, r); chk(r == 0, "R1 cmd reg reset", r, 0);
        chk(mdc == 0 && mdio_oe == 0, "R1 pins idle", {mdc, mdio_oe}, 0);

        // R9 data register
        bus_write(1'b0, 32'hFFFF_A5C3);
        bus_read(1'b0, r); chk(r == 32'h0000_A5C3, "R9 data readback", r, 32'h0000_A5C3);

        // R2 fields stored without a start (R3 no start)
        bus_write(1'b1, 32'hFF00_0000 | cmd_word(1'b1, 1'b1, 9, 5'h15, 5'h0A, 1'b0));
        bus_read(1'b1, r);
        chk(r == cmd_word(1'b1, 1'b1, 9, 5'h15, 5'h0A, 1'b0), "R2 cmd readback", r,
            cmd_word(1'b1, 1'b1, 9, 5'h15, 5'h0A, 1'b0));
        repeat (100) @(negedge clk);
        chk(mdc == 0, "R3 no frame without busy bit", mdc, 0);

        // R4 write frame, divider 0xA
        issue(1'b1, 1'b0, 10, 5'h01, 5'h04, 16'h1234, 16'h0);
        finish_tx(10);

        // R5 read frame, divider 3
        issue(1'b0, 1'b0, 3, 5'h1F, 5'h02, 16'h0, 16'hBEEF);
        finish_tx(3);
        bus_read(1'b0, r); chk(r == 32'h0000_BEEF, "R5 read data", r, 32'h0000_BEEF);

        // R6 preamble skipped on a read, divider 1
        issue(1'b0, 1'b1, 1, 5'h0C, 5'h11, 16'h0, 16'h0F0F);
        finish_tx(1);
        bus_read(1'b0, r); chk(r == 32'h0000_0F0F, "R6 short read data", r, 32'h0000_0F0F);

        // R6 / R7 preamble skipped on a write with divider code 0
        issue(1'b1, 1'b1, 0, 5'h10, 5'h1E, 16'h8001, 16'h0);
        finish_tx(0);

        // R8 command write while busy
        issue(1'b1, 1'b0, 2, 5'h03, 5'h07, 16'hC3A5, 16'h0);
        repeat (200) @(negedge clk);
        bus_write(1'b1, cmd_word(1'b0, 1'b1, 5, 5'h1A, 5'h1B, 1'b1));
        bus_read(1'b1, r);
        chk(r == cmd_word(1'b1, 1'b0, 2, 5'h03, 5'h07, 1'b1), "R8 fields unchanged", r,
            cmd_word(1'b1, 1'b0, 2, 5'h03, 5'h07, 1'b1));
        finish_tx(2);
        repeat (2000) @(negedge clk);
        bus_read(1'b1, r);
        chk(r[17] == 0 && mdc == 0, "R8 no second frame", {r[17], mdc}, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule